// File: doc/BRIEF.md
# Interlaced Line-Type Sequencer

This block follows the vertical position inside a 525-line interlaced frame. Each line-start strobe, when enable is high, moves a 1-based line counter forward by one. Decode logic then classifies the current line. The class is a 4-bit code that names what each half of the line carries: equalizing pulses, broad (serration) sync pulses, a normal sync, active picture, or a line that is one kind for its full length. Downstream sync-shaping or multiplexing logic uses the code to pick what to drive for each half-line.

The classification uses a fixed, ordered list of boundary lines. The counter is compared against every boundary in parallel, and the number of boundaries already reached selects the segment. The first field has 263 lines and the second has 262. A one-cycle pulse marks the wrap from the last line of the frame back to line 1.

Top module: `ilace_linetype_seq`

## Requirements
- R1: After a synchronous active-high reset, the line number is 1, the field flag is 0, the line code is 0 and the frame-start pulse is low.
- R2: On each clock edge where the line strobe and enable are both high, the line number goes up by exactly one. A strobe held high for several cycles advances the count once per cycle.
- R3: On an advancing edge where the line number is 525, the line number becomes 1 and the frame-start output is high for exactly that one following cycle.
- R4: While enable is low, a line strobe is ignored: the line number holds, and no frame-start pulse appears, even at line 525.
- R5: The field flag is 0 for lines 1 through 263 and 1 for lines 264 through 525.
- R6: Line codes are 0 equalizing/equalizing, 1 broad/broad, 2 full-line normal sync, 3 active video, 4 active then equalizing, 5 equalizing then broad, 6 broad then equalizing, 7 full-line equalizing, 8 normal sync then active. No other value ever appears.
- R7: The code follows the line number in the same cycle as that number. Lines 1–3, 7–9, 264–265 and 270–271 give 0. Lines 4–6 and 267–268 give 1. Lines 10–19 and 273–281 give 2. Lines 20–262 and 283–525 give 3. Line 263 gives 4, 266 gives 5, 269 gives 6, 272 gives 7 and 282 gives 8.
- R8: Frame-start is high only in the cycle right after a wrap from 525 to 1. It is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | One pulse per horizontal line start |
| line_en | input | 1 | Allows strobes to advance the counter |
| line_num | output | 10 | Current line, 1 to 525 |
| field_id | output | 1 | 0 in the first field, 1 in the second |
| line_kind | output | 4 | Half-line content code of the current line |
| frame_start | output | 1 | One-cycle pulse on the wrap to line 1 |

## Verification
The assertions assume that the strobe and enable are sampled as clean synchronous levels. They also assume that the counter only ever moves through its own stepping, so it stays in 1..525. They make no claim about cycles before reset is released. The stimulus drives inputs only on the falling clock edge and keeps reset high for several cycles first. It walks two full frames one line at a time and then exercises a held strobe across the wrap. This covers every segment boundary, both field transitions and the enable-low case at the last line.

// File: rtl/ilace_pkg.sv
package ilace_pkg;

    localparam int FRAME_LINES  = 525;
    localparam int FIELD1_LINES = 263;
    localparam int NUM_BP       = 14;   // boundaries inside the frame
    localparam int LINE_W       = 10;

    typedef enum logic [3:0] {
        LK_EQ_EQ      = 4'd0,
        LK_BRD_BRD    = 4'd1,
        LK_FULL_SYNC  = 4'd2,
        LK_VIDEO      = 4'd3,
        LK_VIDEO_EQ   = 4'd4,
        LK_EQ_BRD     = 4'd5,
        LK_BRD_EQ     = 4'd6,
        LK_FULL_EQ    = 4'd7,
        LK_SYNC_VIDEO = 4'd8
    } line_kind_e;

    // First line of segment i+1; segment 0 begins at line 1.
    function automatic int seg_start(input int i);
        case (i)
            0:  return 4;
            1:  return 7;
            2:  return 10;
            3:  return 20;
            4:  return 263;
            5:  return 264;
            6:  return 266;
            7:  return 267;
            8:  return 269;
            9:  return 270;
            10: return 272;
            11: return 273;
            12: return 282;
            default: return 283;
        endcase
    endfunction

    function automatic line_kind_e seg_kind(input logic [3:0] idx);
        case (idx)
            4'd0:  return LK_EQ_EQ;
            4'd1:  return LK_BRD_BRD;
            4'd2:  return LK_EQ_EQ;
            4'd3:  return LK_FULL_SYNC;
            4'd4:  return LK_VIDEO;
            4'd5:  return LK_VIDEO_EQ;
            4'd6:  return LK_EQ_EQ;
            4'd7:  return LK_EQ_BRD;
            4'd8:  return LK_BRD_BRD;
            4'd9:  return LK_BRD_EQ;
            4'd10: return LK_EQ_EQ;
            4'd11: return LK_FULL_EQ;
            4'd12: return LK_FULL_SYNC;
            4'd13: return LK_SYNC_VIDEO;
            default: return LK_VIDEO;
        endcase
    endfunction

endpackage

// File: rtl/ilace_line_counter.sv
module ilace_line_counter #(
    parameter int LINE_W      = ilace_pkg::LINE_W,
    parameter int FRAME_LINES = ilace_pkg::FRAME_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [LINE_W-1:0] line_q,
    output logic              wrap_q
);

    localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(FRAME_LINES);
    localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= FIRST_LINE;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (adv) begin
                if (line_q == LAST_LINE) begin
                    line_q <= FIRST_LINE;
                    wrap_q <= 1'b1;
                end else begin
                    line_q <= line_q + FIRST_LINE;
                end
            end
        end
    end

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (line_q >= FIRST_LINE) && (line_q <= LAST_LINE));                      // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(line_q) != LAST_LINE)
            |-> (line_q == $past(line_q) + FIRST_LINE));                       // R2
    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(line_q) == LAST_LINE)
            |-> (line_q == FIRST_LINE && wrap_q));                             // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(adv)) |-> ($stable(line_q) && !wrap_q));        // R4
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q);                                                   // R8

endmodule

// File: rtl/ilace_seg_decode.sv
module ilace_seg_decode
    import ilace_pkg::*;
#(
    parameter int LINE_W       = ilace_pkg::LINE_W,
    parameter int FIELD1_LINES = ilace_pkg::FIELD1_LINES,
    parameter int NUM_BP       = ilace_pkg::NUM_BP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_i,
    output line_kind_e        kind_o,
    output logic              field_o
);

    localparam int IDX_W = $clog2(NUM_BP + 1);

    logic [NUM_BP-1:0] reached;
    logic [IDX_W-1:0]  seg_idx;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        localparam logic [LINE_W-1:0] START = LINE_W'(seg_start(g));
        assign reached[g] = (line_i >= START);
    end

    always_comb begin
        seg_idx = '0;
        for (int i = 0; i < NUM_BP; i++) begin
            seg_idx = seg_idx + IDX_W'(reached[i]);
        end
    end

    assign kind_o  = seg_kind(4'(seg_idx));
    assign field_o = (line_i > LINE_W'(FIELD1_LINES));

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        kind_o <= LK_SYNC_VIDEO);                                              // R6
    AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(field_o) |-> (line_i == LINE_W'(FIELD1_LINES + 1)));             // R5
    AST_FIELD1_TAIL: assert property (@(posedge clk) disable iff (rst)
        (line_i == LINE_W'(FIELD1_LINES)) |-> (kind_o == LK_VIDEO_EQ && !field_o)); // R7

endmodule

// File: rtl/ilace_linetype_seq.sv
module ilace_linetype_seq
    import ilace_pkg::*;
#(
    parameter int LINE_W = ilace_pkg::LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_strobe,
    input  logic              line_en,
    output logic [LINE_W-1:0] line_num,
    output logic              field_id,
    output logic [3:0]        line_kind,
    output logic              frame_start
);

    logic       adv;
    line_kind_e kind;

    assign adv = line_strobe & line_en;

    ilace_line_counter #(
        .LINE_W      (LINE_W),
        .FRAME_LINES (FRAME_LINES)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .line_q (line_num),
        .wrap_q (frame_start)
    );

    ilace_seg_decode #(
        .LINE_W       (LINE_W),
        .FIELD1_LINES (FIELD1_LINES),
        .NUM_BP       (NUM_BP)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .line_i  (line_num),
        .kind_o  (kind),
        .field_o (field_id)
    );

    assign line_kind = kind;

    AST_START_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (line_num == LINE_W'(1) && !field_id));                // R8
    AST_FIELD_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(field_id) |-> frame_start);                                      // R5

endmodule

// File: tb/ilace_linetype_seq_test.sv
module ilace_linetype_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_strobe = 1'b0;
    logic       line_en = 1'b0;
    logic [9:0] line_num;
    logic       field_id;
    logic [3:0] line_kind;
    logic       frame_start;

    int tests = 0;
    int fails = 0;
    int exp_line = 1;

    always #4 clk = ~clk;

    ilace_linetype_seq uut (
        .clk         (clk),
        .rst         (rst),
        .line_strobe (line_strobe),
        .line_en     (line_en),
        .line_num    (line_num),
        .field_id    (field_id),
        .line_kind   (line_kind),
        .frame_start (frame_start)
    );

    function automatic int want_kind(input int ln);
        if (ln == 263) return 4;
        if (ln == 266) return 5;
        if (ln == 269) return 6;
        if (ln == 272) return 7;
        if (ln == 282) return 8;
        if ((ln >= 4 && ln <= 6) || ln == 267 || ln == 268) return 1;
        if ((ln >= 10 && ln <= 19) || (ln >= 273 && ln <= 281)) return 2;
        if ((ln >= 20 && ln <= 262) || ln >= 283) return 3;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (line %0d)",
                     req, what, act, exp, exp_line);
        end
    endtask

    task automatic check_all(input int fs_exp, input string req_line);
        check(int'(line_num) == exp_line, req_line, "line", int'(line_num), exp_line);
        check(int'(field_id) == (exp_line >= 264 ? 1 : 0), "R5", "field",
              int'(field_id), exp_line >= 264 ? 1 : 0);
        check(int'(line_kind) == want_kind(exp_line), "R7", "kind",
              int'(line_kind), want_kind(exp_line));
        check(int'(line_kind) <= 8, "R6", "kind range", int'(line_kind), 8);
        check(int'(frame_start) == fs_exp, "R8", "frame_start",
              int'(frame_start), fs_exp);
    endtask

    // One strobe cycle; outputs are sampled on the falling edge after it.
    task automatic step(input bit en);
        int fs_exp;
        @(negedge clk);
        line_strobe = 1'b1;
        line_en     = en;
        @(negedge clk);
        line_strobe = 1'b0;
        line_en     = 1'b0;
        fs_exp = 0;
        if (en) begin
            if (exp_line == 525) begin
                exp_line = 1;
                fs_exp = 1;
            end else begin
                exp_line = exp_line + 1;
            end
        end
        check_all(fs_exp, en ? (fs_exp == 1 ? "R3" : "R2") : "R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(line_num == 10'd1, "R1", "reset line", int'(line_num), 1);
        check(field_id == 1'b0, "R1", "reset field", int'(field_id), 0);
        check(line_kind == 4'd0, "R1", "reset kind", int'(line_kind), 0);
        check(frame_start == 1'b0, "R1", "reset frame_start", int'(frame_start), 0);

        // Two full frames, every line compared (R2, R3, R5, R6, R7)
        for (int n = 0; n < 1050; n++) begin
            step(1'b1);
            if (frame_start) begin
                @(negedge clk);
                check(frame_start == 1'b0, "R8", "pulse width", int'(frame_start), 0);
            end
        end

        // R4: strobes with enable low at line 1
        for (int n = 0; n < 3; n++) step(1'b0);

        // Advance to the last line, then strobe with enable low there (R4)
        while (exp_line != 525) step(1'b1);
        step(1'b0);
        step(1'b0);

        // R2/R3: strobe held high for three cycles across the wrap
        @(negedge clk);
        line_strobe = 1'b1;
        line_en     = 1'b1;
        @(negedge clk);
        exp_line = 1;
        check_all(1, "R3");
        @(negedge clk);
        exp_line = 2;
        check_all(0, "R2");
        @(negedge clk);
        line_strobe = 1'b0;
        line_en     = 1'b0;
        exp_line = 3;
        check_all(0, "R2");
        @(negedge clk);
        check_all(0, "R4");

        // R1: reset mid-frame returns to line 1
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_line = 1;
        @(negedge clk);
        check_all(0, "R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule